// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block sits inside an interrupt distributor. For each CPU interface it finds the most urgent interrupt that is both enabled and pending for that CPU. A lower priority value means a more urgent interrupt. The block then decides two things for that CPU: whether the winner is reported as the highest-pending ID, and whether the CPU's interrupt request line is raised.

Two thresholds gate the result. The winner is reported only when its priority is strictly below the CPU's priority mask. The line is raised only when the priority is also strictly below the CPU's running priority. A CPU with no reportable winner sees the spurious ID 1023. Registers, acknowledge and completion handling, and input trigger conditioning are all handled outside this block.

Each CPU has a balanced comparator tree over all interrupts. The tree is followed by one register stage, so every output reflects the inputs sampled at the previous rising clock edge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: For each CPU, the published ID is the interrupt with the numerically lowest 8-bit priority among those whose enable and pending bits are both set for that CPU.
- R2: When several candidates share the lowest priority, the candidate with the lowest interrupt ID is published.
- R3: When a CPU has no interrupt that is both enabled and pending, its published ID is 1023 and its request line is low.
- R4: A winner is published only when its priority is strictly less than that CPU's 8-bit mask. A priority equal to or above the mask gives ID 1023 and a low line.
- R5: A CPU's request line is high only when it has a published winner whose priority is strictly less than its 9-bit running priority. The running-priority value 0x100 means idle, and any published winner raises the line against it.
- R6: While the global distributor enable is low, every CPU publishes 1023 with its line low.
- R7: While one CPU's interface enable is low, that CPU publishes 1023 with its line low, and the other CPUs are unaffected.
- R8: The enable and pending bits are separate for each CPU. Bit `c*N_IRQ+i` of each vector belongs to CPU c, interrupt i. A bit set for one CPU never affects another CPU's result.
- R9: Outputs change exactly one clock after an input change. A synchronous active-low reset sets every ID to 1023 and every line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | N_CPU | Per-CPU interface enable |
| enable_i | input | N_CPU*N_IRQ | Per-CPU enable bits, bit c*N_IRQ+i |
| pending_i | input | N_CPU*N_IRQ | Per-CPU pending bits, bit c*N_IRQ+i |
| prio_i | input | N_IRQ*8 | Priority of interrupt i in bits [8i+7:8i] |
| pmask_i | input | N_CPU*8 | Priority mask of CPU c in bits [8c+7:8c] |
| run_prio_i | input | N_CPU*9 | Running priority of CPU c in bits [9c+8:9c] |
| hp_id_o | output | N_CPU*10 | Highest-pending ID of CPU c in bits [10c+9:10c] |
| irq_o | output | N_CPU | Per-CPU interrupt request line |

## Verification
The hardest situation to reach is an exact boundary. This happens when the winner's priority equals the mask or the running priority, or when it ties with a higher-numbered candidate. It can also happen when the winner falls in a tree half other than the first. Random 8-bit priorities rarely land on these cases.

The directed phase places equal priorities on IDs in different subtrees. It also sets the mask and the running priority to exactly the winner's value and to one above it.

The random phase draws priorities from a narrow range so that ties are frequent. It also draws masks and running priorities from a small set that includes 0, 0x100 and values near the drawn priorities. Every output is compared on every clock against a plain linear search.

// File: rtl/irq_arb_pkg.sv
// Shared widths, constants and the candidate type for the priority arbiter.
package irq_arb_pkg;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;
    localparam int ID_W    = 10;
    localparam logic [ID_W-1:0]    SPURIOUS_ID = 10'd1023;
    localparam logic [RPRIO_W-1:0] NO_PRIO     = 9'h100;

    // Candidate: widened priority (NO_PRIO marks "no candidate") and its ID.
    typedef struct packed {
        logic [RPRIO_W-1:0] prio;
        logic [ID_W-1:0]    id;
    } cand_t;
endpackage

// File: rtl/arb_tree.sv
// Combinational minimum search over N_IRQ candidates for one CPU.
// Assumes: req[i] already combines enable and pending. Leaves are padded to a
// power of two with empty entries. On a tie the left child (lower IDs) wins.
module arb_tree
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ = 64
) (
    input  logic [N_IRQ-1:0]        req,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    output cand_t                   best
);
    localparam int LEAVES = 1 << $clog2(N_IRQ);

    cand_t node [1:2*LEAVES-1];

    // Leaf stage: real interrupts carry their priority when requested.
    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < N_IRQ) begin : g_real
            assign node[LEAVES+l] = req[l]
                ? '{prio: {1'b0, prio[l*PRIO_W +: PRIO_W]}, id: ID_W'(l)}
                : '{prio: NO_PRIO, id: ID_W'(l)};
        end else begin : g_pad
            assign node[LEAVES+l] = '{prio: NO_PRIO, id: SPURIOUS_ID};
        end
    end

    // Inner nodes: right child replaces left only on a strictly lower priority.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        assign node[n] = (node[2*n+1].prio < node[2*n].prio) ? node[2*n+1] : node[2*n];
    end

    assign best = node[1];
endmodule

// File: rtl/arb_gate.sv
// Applies enables, priority mask and running priority to one CPU's winner
// and registers the result.
// Assumes: best.prio == NO_PRIO when nothing is enabled and pending.
module arb_gate
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dist_en,
    input  logic               cpu_en,
    input  logic [PRIO_W-1:0]  pmask,
    input  logic [RPRIO_W-1:0] run_prio,
    input  cand_t              best,
    output logic [ID_W-1:0]    hp_id,
    output logic               irq
);
    logic visible;
    logic raise;

    // Decide whether the winner is published and whether it signals the CPU.
    always_comb begin
        visible = dist_en && cpu_en && (best.prio < {1'b0, pmask});
        raise   = visible && (best.prio < run_prio);
    end

    // Output register: one clock of latency, spurious ID out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_id <= SPURIOUS_ID;
            irq   <= 1'b0;
        end else begin
            hp_id <= visible ? best.id : SPURIOUS_ID;
            irq   <= raise;
        end
    end

    // R6 / R7: a closed gate yields the spurious ID and a low line.
    assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dist_en && cpu_en) |=> (hp_id == SPURIOUS_ID && !irq));

    assert_empty_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (best.prio == NO_PRIO) |=> (hp_id == SPURIOUS_ID && !irq));

    assert_mask_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (best.prio >= {1'b0, pmask}) |=> (hp_id == SPURIOUS_ID));

    assert_running_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (best.prio >= run_prio) |=> !irq);

    // R5: a raised line always comes with a published ID.
    assert_irq_has_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (hp_id != SPURIOUS_ID));
endmodule

// File: rtl/irq_prio_arbiter.sv
// Per-CPU interrupt priority arbiter: one comparator tree and one gate per CPU.
// Assumes: N_IRQ is 32..128 in steps of 32 and N_CPU is 1..8. Priorities are
// shared by all CPUs. Enable and pending are qualified per CPU.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dist_en_i,
    input  logic [N_CPU-1:0]         cpu_en_i,
    input  logic [N_CPU*N_IRQ-1:0]   enable_i,
    input  logic [N_CPU*N_IRQ-1:0]   pending_i,
    input  logic [N_IRQ*PRIO_W-1:0]  prio_i,
    input  logic [N_CPU*PRIO_W-1:0]  pmask_i,
    input  logic [N_CPU*RPRIO_W-1:0] run_prio_i,
    output logic [N_CPU*ID_W-1:0]    hp_id_o,
    output logic [N_CPU-1:0]         irq_o
);
    // R8: each CPU gets its own candidate slice and its own tree.
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [N_IRQ-1:0] req;
        cand_t            best;

        assign req = enable_i[c*N_IRQ +: N_IRQ] & pending_i[c*N_IRQ +: N_IRQ];

        arb_tree #(.N_IRQ(N_IRQ)) u_tree (
            .req  (req),
            .prio (prio_i),
            .best (best)
        );

        arb_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .dist_en  (dist_en_i),
            .cpu_en   (cpu_en_i[c]),
            .pmask    (pmask_i[c*PRIO_W +: PRIO_W]),
            .run_prio (run_prio_i[c*RPRIO_W +: RPRIO_W]),
            .best     (best),
            .hp_id    (hp_id_o[c*ID_W +: ID_W]),
            .irq      (irq_o[c])
        );
    end
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
// Bench: directed corner cases plus randomized states, each checked on every
// clock against a linear-search reference model.
module irq_prio_arbiter_tb_top;
    localparam int NC = 4;
    localparam int NI = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              dist_en;
    logic [NC-1:0]     cpu_en;
    logic [NC*NI-1:0]  en_v;
    logic [NC*NI-1:0]  pend_v;
    logic [NI*8-1:0]   prio_v;
    logic [NC*8-1:0]   pmask_v;
    logic [NC*9-1:0]   run_v;
    logic [NC*10-1:0]  hp_id;
    logic [NC-1:0]     irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int    exp_id  [NC];
    bit    exp_irq [NC];
    string exp_tag [NC];

    always #4 clk = ~clk;

    irq_prio_arbiter #(.N_CPU(NC), .N_IRQ(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
        .enable_i(en_v), .pending_i(pend_v), .prio_i(prio_v),
        .pmask_i(pmask_v), .run_prio_i(run_v), .hp_id_o(hp_id), .irq_o(irq)
    );

    // Compare one value and record the outcome.
    task automatic chk(string tag, string what, int got, int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // Reference: plain linear search per CPU, then the two threshold gates.
    task automatic calc_expected();
        for (int c = 0; c < NC; c++) begin
            int best_p = 256;
            int best_i = 1023;
            for (int i = 0; i < NI; i++) begin
                if (en_v[c*NI+i] && pend_v[c*NI+i] && int'(prio_v[i*8 +: 8]) < best_p) begin
                    best_p = int'(prio_v[i*8 +: 8]);
                    best_i = i;
                end
            end
            exp_id[c]  = 1023;
            exp_irq[c] = 0;
            if (!dist_en) exp_tag[c] = "R6";
            else if (!cpu_en[c]) exp_tag[c] = "R7";
            else if (best_p == 256) exp_tag[c] = "R3";
            else if (best_p >= int'(pmask_v[c*8 +: 8])) exp_tag[c] = "R4";
            else begin
                exp_tag[c] = "R1";
                exp_id[c]  = best_i;
                if (best_p < int'(run_v[c*9 +: 9])) exp_irq[c] = 1;
            end
        end
    endtask

    // Check all CPUs against the current expectation.
    task automatic check_all(string tag_override);
        for (int c = 0; c < NC; c++) begin
            string t = (tag_override != "") ? tag_override : exp_tag[c];
            chk(t, $sformatf("cpu%0d id", c), int'(hp_id[c*10 +: 10]), exp_id[c]);
            chk((t == "R1") ? "R5" : t, $sformatf("cpu%0d irq", c), int'(irq[c]), int'(exp_irq[c]));
        end
    endtask

    // Inputs are already set (at a negedge). Let one edge pass, then compare.
    task automatic step(string tag_override);
        calc_expected();
        @(posedge clk);
        #1;
        check_all(tag_override);
        @(negedge clk);
    endtask

    task automatic clear_all();
        en_v = '0; pend_v = '0; prio_v = '0;
        pmask_v = {NC{8'hFF}};
        run_v   = {NC{9'h100}};
        dist_en = 1'b1;
        cpu_en  = '1;
    endtask

    task automatic make_cand(int c, int i, int p);
        en_v[c*NI+i]   = 1'b1;
        pend_v[c*NI+i] = 1'b1;
        prio_v[i*8 +: 8] = 8'(p);
    endtask

    initial begin
        rst_n = 1'b0;
        clear_all();
        make_cand(0, 3, 1);
        // R9: reset state
        @(posedge clk); #1;
        for (int c = 0; c < NC; c++) begin
            chk("R9", "reset id", int'(hp_id[c*10 +: 10]), 1023);
            chk("R9", "reset irq", int'(irq[c]), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        clear_all();

        // R3: nothing pending
        step("R3");

        // R1: lowest value wins, winner in the upper half of the tree
        make_cand(0, 5, 8'h40); make_cand(0, 50, 8'h20); make_cand(0, 9, 8'h30);
        step("");
        chk("R1", "cpu0 winner", int'(hp_id[9:0]), 50);

        // R2: tie at 0x10 between IDs 12 and 40; the lower ID wins
        make_cand(0, 12, 8'h10); make_cand(0, 40, 8'h10);
        step("");
        chk("R2", "tie winner", int'(hp_id[9:0]), 12);

        // R8: CPU1 sees only its own candidate
        make_cand(1, 60, 8'h05);
        pend_v[0*NI+60] = 1'b0;
        step("");
        chk("R8", "cpu0 unaffected", int'(hp_id[9:0]), 12);
        chk("R8", "cpu1 own winner", int'(hp_id[19:10]), 60);

        // R4: mask equal to the winner's priority hides it; one above shows it
        pmask_v[7:0] = 8'h10;
        step("R4");
        pmask_v[7:0] = 8'h11;
        step("");
        chk("R4", "mask+1 publishes", int'(hp_id[9:0]), 12);

        // R5: running priority equal to the winner blocks; one above raises; idle raises
        run_v[8:0] = 9'h010;
        step("");
        chk("R5", "run equal irq", int'(irq[0]), 0);
        chk("R5", "run equal id still shown", int'(hp_id[9:0]), 12);
        run_v[8:0] = 9'h011;
        step("");
        chk("R5", "run+1 irq", int'(irq[0]), 1);
        run_v[8:0] = 9'h100;
        step("");
        chk("R5", "idle irq", int'(irq[0]), 1);

        // R7: CPU0 interface off, CPU1 unaffected
        cpu_en[0] = 1'b0;
        step("");
        chk("R7", "cpu1 kept", int'(irq[1]), 1);

        // R9: latency. Before the edge the old value holds; after it the new one.
        cpu_en[0] = 1'b1;
        dist_en   = 1'b0;
        #1;
        chk("R9", "old value before edge", int'(hp_id[9:0]), 1023);
        // R6: distributor disabled
        step("R6");
        dist_en = 1'b1;
        step("");
        chk("R9", "reopened next clock", int'(hp_id[9:0]), 12);

        // Random phase: narrow priorities for ties, boundary thresholds
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NI; i++) prio_v[i*8 +: 8] = 8'($urandom_range(0, 12));
            for (int b = 0; b < NC*NI; b++) begin
                en_v[b]   = ($urandom_range(0, 3) != 0);
                pend_v[b] = ($urandom_range(0, 11) == 0);
            end
            for (int c = 0; c < NC; c++) begin
                int sel = $urandom_range(0, 3);
                pmask_v[c*8 +: 8] = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : 8'($urandom_range(0, 13));
                sel = $urandom_range(0, 3);
                run_v[c*9 +: 9] = (sel == 0) ? 9'h100 : (sel == 1) ? 9'h000 : 9'($urandom_range(0, 13));
                cpu_en[c] = ($urandom_range(0, 9) != 0);
            end
            dist_en = ($urandom_range(0, 19) != 0);
            step("");
        end
        done = 1;
    end

    // Watchdog and summary
    initial begin
        for (int k = 0; k < 200000 && !done; k++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule